// File: doc/BRIEF.md
# Timer Compare Unit with Period Trigger

This block pairs a 16-bit up-counting timer with a 16-bit compare register. On each clock the counter value is compared with the compare register. A 4-bit compare mode selects what a match does. It can drive a dedicated output latch high, drive it low, or only raise an interrupt flag. The fourth action is a period trigger. The trigger pulses at once, and the counter is then cleared on the next timer tick, so the compare register acts as a programmable period. The trigger also pulses a conversion-start output when the converter enable input is high.

Software reaches the block through one register-write port. Seven write selects cover the timer bytes, the compare bytes, timer control, compare control and the flag clear. The timer advances on every clock (internal source) or on `tick_in` (external source), after a power-of-two prescaler. The compare logic is a four-state machine:

- `ST_OFF`: compare is disabled, or the timer runs unsynchronised.
- `ST_WATCH`: waiting for a match. The state leaves on a match and fires the event.
- `ST_HELD`: the match is still present after an output, flag or interrupt-only event. The state returns to `ST_WATCH` when the match drops.
- `ST_CLR_PEND`: trigger mode, waiting for the timer tick that clears the counter. The state returns to `ST_WATCH` on that tick, or earlier if the match drops.

Every state falls back to `ST_OFF` when compare becomes inactive. `ST_OFF` moves to `ST_WATCH` one cycle after compare becomes active.

Top module: `tcmp_unit`

## Requirements
- R1: After reset, the counter, compare register, timer control and compare mode are zero, and `cmp_pin`, `irq_flag`, `trig_pulse` and `conv_start` are low.
- R2: Write select 0 loads the counter's low byte and select 1 its high byte, visible one cycle after the write. A counter byte write takes priority over a timer tick in the same cycle. A counter byte write also clears the prescaler.
- R3: In timer control, bit 0 enables counting and bit 1 selects the source: 0 advances on every clock, 1 advances on `tick_in`. With bit 0 low the counter holds its value.
- R4: Timer control bits 5:4 divide the source by 1, 2, 4 or 8 (values 0 to 3). With division N, the first counter step after a counter write comes on the N-th source tick.
- R5: Compare mode 4'b1000 sets `cmp_pin` high in the cycle after the first cycle of a match.
- R6: Compare mode 4'b1001 drives `cmp_pin` low in the cycle after the first cycle of a match.
- R7: Compare mode 4'b1010 sets only the interrupt flag on a match and leaves `cmp_pin` unchanged.
- R8: A compare control write (select 5) whose mode field (bits 3:0) is 4'b0000 forces `cmp_pin` low. Mode 4'b0000 produces no match events.
- R9: `irq_flag` rises once for each match in any compare mode 4'b1000 to 4'b1011 and stays set while the match persists. A write to select 6 clears it. A match in the same cycle as that write leaves it set.
- R10: In mode 4'b1011, `trig_pulse` is high for exactly the first cycle in which the counter equals the compare register. `conv_start` pulses in that same cycle only when `adc_en` is high.
- R11: In mode 4'b1011, the counter is not cleared by the match itself. It becomes zero on the next timer tick, giving a period of compare value plus one ticks.
- R12: If the compare register is rewritten after a trigger so that it no longer equals the counter, the pending clear is dropped and the next tick increments the counter.
- R13: With external source and timer control bit 2 set (unsynchronised counting), no match events occur, though the counter still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write select: 0/1 counter low/high, 2/3 compare low/high, 4 timer control, 5 compare control, 6 flag clear |
| wr_data | input | 8 | Write data |
| tick_in | input | 1 | External timer tick, one-cycle strobe |
| adc_en | input | 1 | Converter enable, gates `conv_start` |
| cmp_pin | output | 1 | Compare output latch |
| irq_flag | output | 1 | Sticky compare interrupt flag |
| trig_pulse | output | 1 | Period trigger pulse |
| conv_start | output | 1 | Conversion-start pulse |
| tmr_count | output | 16 | Current counter value |

## Verification
Two pairs of actions can fall in the same cycle. In the first, a flag-clear write lands in the very cycle of a new match. The bench raises the tick so that the counter reaches the compare value on one edge, then issues the clear write in the next cycle. It then expects `irq_flag` still set. In the second, the compare register is rewritten while a period clear is pending. The bench expects the following tick to increment the counter rather than clear it. A counter byte write that coincides with an internal-source tick is also checked: the written value must win.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    // write select codes
    localparam logic [2:0] SEL_TMR_LO  = 3'd0;
    localparam logic [2:0] SEL_TMR_HI  = 3'd1;
    localparam logic [2:0] SEL_CMP_LO  = 3'd2;
    localparam logic [2:0] SEL_CMP_HI  = 3'd3;
    localparam logic [2:0] SEL_TCTL    = 3'd4;
    localparam logic [2:0] SEL_CCTL    = 3'd5;
    localparam logic [2:0] SEL_FLAGCLR = 3'd6;

    // compare modes
    localparam logic [3:0] MODE_OFF  = 4'b0000;
    localparam logic [3:0] MODE_SET  = 4'b1000;
    localparam logic [3:0] MODE_CLR  = 4'b1001;
    localparam logic [3:0] MODE_SWI  = 4'b1010;
    localparam logic [3:0] MODE_TRIG = 4'b1011;

    // timer control bit positions
    localparam int TC_RUN    = 0;
    localparam int TC_SRC    = 1;
    localparam int TC_NOSYNC = 2;
    localparam int TC_PS_LO  = 4;

    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_WATCH    = 2'd1,
        ST_HELD     = 2'd2,
        ST_CLR_PEND = 2'd3
    } cmp_state_e;

endpackage

// File: rtl/tcmp_regs.sv
module tcmp_regs
    import tcmp_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PS_W   = 2,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cmp_q,
    output logic [PS_W-1:0]   ps_q,
    output logic              run_q,
    output logic              src_ext_q,
    output logic              nosync_q,
    output logic [3:0]        mode_q,
    output logic              tlo_wr,
    output logic              thi_wr,
    output logic              zero_wr,
    output logic              fclr_wr
);

    logic cmp_lo_wr, cmp_hi_wr, tctl_wr, cctl_wr;

    always_comb begin
        tlo_wr    = wr_en && (wr_sel == SEL_TMR_LO);
        thi_wr    = wr_en && (wr_sel == SEL_TMR_HI);
        cmp_lo_wr = wr_en && (wr_sel == SEL_CMP_LO);
        cmp_hi_wr = wr_en && (wr_sel == SEL_CMP_HI);
        tctl_wr   = wr_en && (wr_sel == SEL_TCTL);
        cctl_wr   = wr_en && (wr_sel == SEL_CCTL);
        fclr_wr   = wr_en && (wr_sel == SEL_FLAGCLR);
        zero_wr   = cctl_wr && (wr_data[3:0] == MODE_OFF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else begin
            if (cmp_lo_wr) cmp_q[BYTE_W-1:0]     <= wr_data;
            if (cmp_hi_wr) cmp_q[CNT_W-1:BYTE_W] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q      <= '0;
            run_q     <= 1'b0;
            src_ext_q <= 1'b0;
            nosync_q  <= 1'b0;
        end else if (tctl_wr) begin
            ps_q      <= wr_data[TC_PS_LO +: PS_W];
            run_q     <= wr_data[TC_RUN];
            src_ext_q <= wr_data[TC_SRC];
            nosync_q  <= wr_data[TC_NOSYNC];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_q <= MODE_OFF;
        else if (cctl_wr) mode_q <= wr_data[3:0];
    end

endmodule

// File: rtl/tcmp_prescaler.sv
module tcmp_prescaler #(
    parameter int PS_W  = 2,
    localparam int PRE_W = (1 << PS_W) - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_tick,
    input  logic            clr,
    input  logic [PS_W-1:0] ps,
    output logic            tick_out
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < int'(ps));
        end
        tick_out = raw_tick && ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pre_q <= '0;
        else if (clr)      pre_q <= '0;
        else if (raw_tick) pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/tcmp_counter.sv
module tcmp_counter #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              clr_req,
    output logic [CNT_W-1:0]  count_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (lo_wr || hi_wr) begin
            if (lo_wr) count_q[BYTE_W-1:0]     <= wr_data;
            if (hi_wr) count_q[CNT_W-1:BYTE_W] <= wr_data;
        end else if (tick) begin
            count_q <= clr_req ? '0 : count_q + 1'b1;
        end
    end

    AST_CLEAR_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) (clr_req && tick && !lo_wr && !hi_wr) |=> (count_q == '0)); // R11

endmodule

// File: rtl/tcmp_cmp_fsm.sv
module tcmp_cmp_fsm
    import tcmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    input  logic [3:0]       mode,
    input  logic             cmp_ok,
    input  logic             tick,
    input  logic             adc_en,
    input  logic             zero_wr,
    input  logic             fclr_wr,
    output logic             pin_q,
    output logic             irq_q,
    output logic             trig,
    output logic             conv,
    output logic             clr_req
);

    cmp_state_e st_q, st_nxt;
    logic       active, hit, trig_mode, evt;

    always_comb begin
        active    = (mode[3:2] == 2'b10) && cmp_ok;
        hit       = (count == cmp);
        trig_mode = (mode == MODE_TRIG);
    end

    // next-state logic
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_OFF: begin
                if (active) st_nxt = ST_WATCH;
            end
            ST_WATCH: begin
                if (!active)  st_nxt = ST_OFF;
                else if (hit) st_nxt = trig_mode ? ST_CLR_PEND : ST_HELD;
            end
            ST_HELD: begin
                if (!active)   st_nxt = ST_OFF;
                else if (!hit) st_nxt = ST_WATCH;
            end
            ST_CLR_PEND: begin
                if (!active)            st_nxt = ST_OFF;
                else if (!hit || tick)  st_nxt = ST_WATCH;
            end
            default: st_nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_nxt;
    end

    // outputs
    always_comb begin
        evt     = 1'b0;
        clr_req = 1'b0;
        unique case (st_q)
            ST_WATCH:    evt     = active && hit;
            ST_CLR_PEND: clr_req = active && hit && tick;
            ST_OFF, ST_HELD: ;
            default: ;
        endcase
        trig = evt && trig_mode;
        conv = trig && adc_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            pin_q <= 1'b0;
        else if (zero_wr)                      pin_q <= 1'b0;
        else if (evt && (mode == MODE_SET))    pin_q <= 1'b1;
        else if (evt && (mode == MODE_CLR))    pin_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (evt)     irq_q <= 1'b1;
        else if (fclr_wr) irq_q <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (irq_q && !fclr_wr) |=> irq_q); // R9
    AST_SWI_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ((mode == MODE_SWI) && !zero_wr) |=> $stable(pin_q)); // R7
    AST_CONV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) conv |=> !conv); // R10
    AST_ZERO_FORCE: assert property (@(posedge clk) disable iff (!rst_n) zero_wr |=> !pin_q); // R8

endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
    import tcmp_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PS_W   = 2,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              tick_in,
    input  logic              adc_en,
    output logic              cmp_pin,
    output logic              irq_flag,
    output logic              trig_pulse,
    output logic              conv_start,
    output logic [CNT_W-1:0]  tmr_count
);

    logic [CNT_W-1:0] cmp_q;
    logic [PS_W-1:0]  ps_q;
    logic             run_q, src_ext_q, nosync_q;
    logic [3:0]       mode_q;
    logic             tlo_wr, thi_wr, zero_wr, fclr_wr;
    logic             raw_tick, tmr_tick, clr_req, cmp_ok;

    tcmp_regs #(.BYTE_W(BYTE_W), .PS_W(PS_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .cmp_q     (cmp_q),
        .ps_q      (ps_q),
        .run_q     (run_q),
        .src_ext_q (src_ext_q),
        .nosync_q  (nosync_q),
        .mode_q    (mode_q),
        .tlo_wr    (tlo_wr),
        .thi_wr    (thi_wr),
        .zero_wr   (zero_wr),
        .fclr_wr   (fclr_wr)
    );

    always_comb begin
        raw_tick = run_q && (src_ext_q ? tick_in : 1'b1);
        cmp_ok   = !(src_ext_q && nosync_q);
    end

    tcmp_prescaler #(.PS_W(PS_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_tick (raw_tick),
        .clr      (tlo_wr || thi_wr),
        .ps       (ps_q),
        .tick_out (tmr_tick)
    );

    tcmp_counter #(.BYTE_W(BYTE_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tmr_tick),
        .lo_wr   (tlo_wr),
        .hi_wr   (thi_wr),
        .wr_data (wr_data),
        .clr_req (clr_req),
        .count_q (tmr_count)
    );

    tcmp_cmp_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (tmr_count),
        .cmp     (cmp_q),
        .mode    (mode_q),
        .cmp_ok  (cmp_ok),
        .tick    (tmr_tick),
        .adc_en  (adc_en),
        .zero_wr (zero_wr),
        .fclr_wr (fclr_wr),
        .pin_q   (cmp_pin),
        .irq_q   (irq_flag),
        .trig    (trig_pulse),
        .conv    (conv_start),
        .clr_req (clr_req)
    );

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!run_q && !tlo_wr && !thi_wr) |=> $stable(tmr_count)); // R3
    AST_ASYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (src_ext_q && nosync_q && !zero_wr) |=> $stable(cmp_pin)); // R13
    AST_ASYNC_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (src_ext_q && nosync_q) |=> !$rose(irq_flag)); // R13

endmodule

// File: tb/tcmp_unit_bench.sv
module tcmp_unit_bench;
    import tcmp_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        tick_in = 1'b0;
    logic        adc_en = 1'b1;
    logic        cmp_pin, irq_flag, trig_pulse, conv_start;
    logic [15:0] tmr_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tcmp_unit u_tcmp_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .tick_in    (tick_in),
        .adc_en     (adc_en),
        .cmp_pin    (cmp_pin),
        .irq_flag   (irq_flag),
        .trig_pulse (trig_pulse),
        .conv_start (conv_start),
        .tmr_count  (tmr_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_in = 1'b1;
            @(negedge clk);
            tick_in = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 pin", cmp_pin, 0);
        chk("R1 irq", irq_flag, 0);
        chk("R1 trig", trig_pulse, 0);
        chk("R1 conv", conv_start, 0);
        chk("R1 count", tmr_count, 0);
    endtask

    task automatic t_load;
        wr(SEL_TCTL, 8'h03);
        wr(SEL_TMR_LO, 8'h34);
        wr(SEL_TMR_HI, 8'h12);
        chk("R2 byte load", tmr_count, 16'h1234);
    endtask

    task automatic t_count;
        tick(3);
        chk("R3 external ticks", tmr_count, 16'h1237);
    endtask

    task automatic t_prescale;
        wr(SEL_TCTL, 8'h23);
        wr(SEL_TMR_LO, 8'h00);
        tick(3);
        chk("R4 div4 held", tmr_count, 16'h1200);
        tick(1);
        chk("R4 div4 step", tmr_count, 16'h1201);
        tick(8);
        chk("R4 div4 run", tmr_count, 16'h1203);
        wr(SEL_TCTL, 8'h13);
        wr(SEL_TMR_LO, 8'h00);
        tick(4);
        chk("R4 div2", tmr_count, 16'h1202);
        wr(SEL_TCTL, 8'h03);
    endtask

    task automatic t_set_high;
        wr(SEL_CMP_LO, 8'h05);
        wr(SEL_CMP_HI, 8'h00);
        wr(SEL_TMR_LO, 8'h03);
        wr(SEL_TMR_HI, 8'h00);
        wr(SEL_CCTL, 8'h08);
        tick(2);
        chk("R5 pin before", cmp_pin, 0);
        chk("R10 no trig in set mode", trig_pulse, 0);
        idle(1);
        chk("R5 pin high", cmp_pin, 1);
        chk("R9 irq on set", irq_flag, 1);
    endtask

    task automatic t_flag_clear;
        wr(SEL_FLAGCLR, 8'h00);
        chk("R9 cleared", irq_flag, 0);
        idle(2);
        chk("R9 no refire on held match", irq_flag, 0);
    endtask

    task automatic t_set_low;
        wr(SEL_CCTL, 8'h09);
        wr(SEL_TMR_LO, 8'h00);
        tick(5);
        idle(1);
        chk("R6 pin low", cmp_pin, 0);
        chk("R9 irq on clr mode", irq_flag, 1);
        wr(SEL_FLAGCLR, 8'h00);
    endtask

    task automatic t_swi;
        wr(SEL_CCTL, 8'h08);
        wr(SEL_TMR_LO, 8'h00);
        tick(5);
        idle(1);
        chk("R5 pin high again", cmp_pin, 1);
        wr(SEL_FLAGCLR, 8'h00);
        wr(SEL_CCTL, 8'h0A);
        wr(SEL_TMR_LO, 8'h00);
        tick(5);
        idle(1);
        chk("R7 pin unchanged", cmp_pin, 1);
        chk("R7 irq set", irq_flag, 1);
    endtask

    task automatic t_zero;
        wr(SEL_CCTL, 8'h00);
        chk("R8 forced low", cmp_pin, 0);
        wr(SEL_FLAGCLR, 8'h00);
        wr(SEL_TMR_LO, 8'h00);
        tick(5);
        idle(2);
        chk("R8 off no irq", irq_flag, 0);
        chk("R8 off count", tmr_count, 16'h0005);
    endtask

    task automatic t_trigger;
        wr(SEL_CMP_LO, 8'h04);
        wr(SEL_TMR_LO, 8'h00);
        wr(SEL_CCTL, 8'h0B);
        tick(4);
        chk("R10 trig on match", trig_pulse, 1);
        chk("R10 conv on match", conv_start, 1);
        chk("R11 not cleared at match", tmr_count, 16'h0004);
        idle(1);
        chk("R10 conv single", conv_start, 0);
        chk("R11 still held", tmr_count, 16'h0004);
        chk("R9 irq in trig mode", irq_flag, 1);
        tick(1);
        chk("R11 cleared on tick", tmr_count, 16'h0000);
        tick(4);
        chk("R11 period repeats", trig_pulse, 1);
        idle(1);
    endtask

    task automatic t_cancel;
        wr(SEL_CMP_LO, 8'h09);
        tick(1);
        chk("R12 clear dropped", tmr_count, 16'h0005);
    endtask

    task automatic t_no_adc;
        adc_en = 1'b0;
        wr(SEL_TMR_LO, 8'h00);
        wr(SEL_CMP_LO, 8'h04);
        tick(4);
        chk("R10 trig without adc", trig_pulse, 1);
        chk("R10 conv gated", conv_start, 0);
        idle(1);
        tick(1);
        chk("R11 clear without adc", tmr_count, 16'h0000);
        adc_en = 1'b1;
    endtask

    task automatic t_async;
        wr(SEL_CCTL, 8'h00);
        wr(SEL_CCTL, 8'h08);
        wr(SEL_FLAGCLR, 8'h00);
        wr(SEL_TCTL, 8'h07);
        wr(SEL_TMR_LO, 8'h00);
        tick(4);
        idle(2);
        chk("R13 async counts", tmr_count, 16'h0004);
        chk("R13 async pin", cmp_pin, 0);
        chk("R13 async irq", irq_flag, 0);
    endtask

    task automatic t_halt;
        wr(SEL_TCTL, 8'h02);
        wr(SEL_TMR_LO, 8'h00);
        tick(3);
        chk("R3 halted", tmr_count, 16'h0000);
    endtask

    task automatic t_collision;
        wr(SEL_TCTL, 8'h03);
        wr(SEL_FLAGCLR, 8'h00);
        wr(SEL_TMR_LO, 8'h00);
        tick(3);
        @(negedge clk);
        tick_in = 1'b1;
        @(negedge clk);
        tick_in = 1'b0;
        wr_en = 1'b1; wr_sel = SEL_FLAGCLR; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 set beats clear", irq_flag, 1);
        chk("R5 pin on collision", cmp_pin, 1);
    endtask

    task automatic t_timer_mode;
        wr(SEL_CCTL, 8'h00);
        wr(SEL_TCTL, 8'h01);
        wr(SEL_TMR_LO, 8'h00);
        chk("R2 write beats tick", tmr_count[7:0], 8'h00);
        idle(5);
        chk("R3 internal source", tmr_count[7:0], 8'h05);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_count();
        t_prescale();
        t_set_high();
        t_flag_clear();
        t_set_low();
        t_swi();
        t_zero();
        t_trigger();
        t_cancel();
        t_no_adc();
        t_async();
        t_halt();
        t_collision();
        t_timer_mode();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule